// File: doc/BRIEF.md
# Nine-bit serial command writer

This block writes configuration frames to a display controller over a three-wire serial link made of an active-low chip-select, a serial clock and a data-out line. A frame is made of nine-bit words. The first word carries a register address and the later words carry payload bytes. The most significant bit of each word marks whether the word is a command or a data byte. The link carries writes only. A data-in line is tied back to the controller's data pin, and the block compares it with every bit it drives, so a stuck or shorted line is caught on the bit where it first shows.

The host places an 8-bit address, a 16-bit payload and a word count on the inputs and pulses `start`. The block sends the frame with bit timing derived from a half-period counter of `HALF_CYC` system clocks. It then pulses `done` for one cycle, with `err` set if an echo mismatch cut the frame short. An aborted frame leaves chip-select low. The next accepted start first raises chip-select for one half-period, so the controller sees a clean frame boundary before the new frame begins.

Top module: `nbw_writer`

## Requirements
- R1: After reset, `cs_n` and `sclk` are 1, `sdo` is 0, and `busy` and `done` are 0.
- R2: Every word is 9 bits and is sent most significant bit first. Bit 8 is 0 in the address word and 1 in each data word, and bits 7:0 carry the byte.
- R3: `words` selects the frame length. A value of 0 or 1 sends only the address word. A value of 2 sends the address word, then `payload[7:0]`. A value of 3 sends the address word, then `payload[15:8]`, then `payload[7:0]`.
- R4: `cs_n` falls one half-period before the first falling edge of `sclk`. It stays low through every word of the frame, and on a clean frame it rises in the same cycle that `done` pulses.
- R5: For each bit, `sclk` is low for `HALF_CYC` clocks with `sdo` holding the bit, then high for `HALF_CYC` clocks. `sclk` rests high between clean frames.
- R6: On the last clock of each low half-period, `sdi` is compared with `sdo`. On a mismatch the frame stops with no rising `sclk` for that bit, `done` and `err` are set, and `cs_n` stays low.
- R7: `done` is high for exactly one cycle at the end of every frame, whether the frame completed or was aborted. `err` is 0 after a clean frame and holds its value until the next accepted start.
- R8: A `start` that arrives while `busy` is 1 is ignored. The frame in progress is unchanged and no extra frame follows.
- R9: When the previous frame was aborted, the next accepted start holds `cs_n` high for `HALF_CYC` clocks before it drives `cs_n` low. Otherwise `cs_n` goes low in the cycle after `start`.
- R10: `busy` is 1 from the cycle after an accepted start until the cycle in which `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a frame, sampled while idle |
| words | input | 2 | Number of words in the frame (0 or 1, 2, 3) |
| reg_addr | input | 8 | Register address, sent in the address word |
| payload | input | 16 | Payload bytes, high byte used only for 3-word frames |
| sdi | input | 1 | Echo of the controller data pin |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock, rests high |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last frame aborted on an echo mismatch |

## Verification
A wrong bit or word index appears on the serial data line within the half-period that carries the affected bit. The bench rebuilds the expected bit stream arithmetically and compares it against the bits captured on each rising `sclk`. A broken half-period counter shows in the first measured low or high run of `sclk`, and a lost abort flag shows as a missing chip-select gap at the next start. A misrouted echo check shows as an early or missing `err`, detected at the `done` pulse by comparing the number of clock pulses seen against the injected fault position.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
    localparam int WORD_W = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } nbw_state_e;

    typedef struct packed {
        nbw_state_e          st;
        logic                cs_n;
        logic                sclk;
        logic                sdo;
        logic                done;
        logic                err;
        logic                aborted;
        logic [1:0]          widx;
        logic [3:0]          bidx;
        logic [BYTE_W-1:0]   addr;
        logic [2*BYTE_W-1:0] pay;
        logic [1:0]          cnt;
    } nbw_regs_t;
endpackage

// File: rtl/nbw_half_timer.sv
module nbw_half_timer #(
    parameter int HALF_CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = TOP;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

    // R5
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/nbw_word_sel.sv
module nbw_word_sel
    import nbw_pkg::*;
(
    input  logic [BYTE_W-1:0]   addr,
    input  logic [2*BYTE_W-1:0] pay,
    input  logic [1:0]          cnt,
    input  logic [1:0]          idx,
    output logic [WORD_W-1:0]   word
);
    always_comb begin
        unique case (idx)
            2'd0:    word = {1'b0, addr};
            2'd1:    word = (cnt == 2'd3) ? {1'b1, pay[2*BYTE_W-1:BYTE_W]}
                                          : {1'b1, pay[BYTE_W-1:0]};
            default: word = {1'b1, pay[BYTE_W-1:0]};
        endcase
    end
endmodule

// File: rtl/nbw_writer.sv
module nbw_writer
    import nbw_pkg::*;
#(
    parameter int HALF_CYC = 40000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  words,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] payload,
    input  logic        sdi,
    output logic        cs_n,
    output logic        sclk,
    output logic        sdo,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam nbw_regs_t RST_VAL = '{
        st: ST_IDLE, cs_n: 1'b1, sclk: 1'b1, sdo: 1'b0, done: 1'b0,
        err: 1'b0, aborted: 1'b0, widx: 2'd0, bidx: 4'd8,
        addr: '0, pay: '0, cnt: '0};

    nbw_regs_t r_d, r_q;
    logic            tick, load;
    logic [1:0]      sel_idx, last_idx;
    logic [3:0]      sel_bit;
    logic [WORD_W-1:0] word;
    logic            next_bit;

    nbw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick));

    nbw_word_sel u_sel (
        .addr(r_q.addr), .pay(r_q.pay), .cnt(r_q.cnt),
        .idx(sel_idx), .word(word));

    // word and bit that the next low half-period will carry
    always_comb begin
        last_idx = (r_q.cnt <= 2'd1) ? 2'd0 : r_q.cnt - 2'd1;
        sel_idx  = r_q.widx;
        sel_bit  = r_q.bidx;
        if (r_q.st == ST_HIGH) begin
            if (r_q.bidx == 4'd0) begin
                sel_idx = r_q.widx + 2'd1;
                sel_bit = 4'd8;
            end else begin
                sel_bit = r_q.bidx - 4'd1;
            end
        end else if (r_q.st != ST_LOW) begin
            sel_idx = 2'd0;
            sel_bit = 4'd8;
        end
        next_bit = word[sel_bit];
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                load = 1'b1;
                if (start) begin
                    r_d.addr = reg_addr;
                    r_d.pay  = payload;
                    r_d.cnt  = words;
                    r_d.err  = 1'b0;
                    r_d.widx = 2'd0;
                    r_d.bidx = 4'd8;
                    if (r_q.aborted) begin
                        r_d.st      = ST_GAP;
                        r_d.cs_n    = 1'b1;
                        r_d.sclk    = 1'b1;
                        r_d.sdo     = 1'b0;
                        r_d.aborted = 1'b0;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.cs_n = 1'b0;
                    end
                end
            end
            ST_GAP: if (tick) begin
                load     = 1'b1;
                r_d.st   = ST_SETUP;
                r_d.cs_n = 1'b0;
            end
            ST_SETUP: if (tick) begin
                load     = 1'b1;
                r_d.st   = ST_LOW;
                r_d.sclk = 1'b0;
                r_d.sdo  = next_bit;
            end
            ST_LOW: if (tick) begin
                load = 1'b1;
                if (sdi != r_q.sdo) begin
                    r_d.st      = ST_IDLE;
                    r_d.err     = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.aborted = 1'b1;
                end else begin
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                end
            end
            ST_HIGH: if (tick) begin
                load = 1'b1;
                if (r_q.bidx == 4'd0 && r_q.widx == last_idx) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.sdo  = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    if (r_q.bidx == 4'd0) begin
                        r_d.widx = r_q.widx + 2'd1;
                        r_d.bidx = 4'd8;
                    end else begin
                        r_d.bidx = r_q.bidx - 4'd1;
                    end
                    r_d.st   = ST_LOW;
                    r_d.sclk = 1'b0;
                    r_d.sdo  = next_bit;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign cs_n = r_q.cs_n;
    assign sclk = r_q.sclk;
    assign sdo  = r_q.sdo;
    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;
    assign err  = r_q.err;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R4
    cs_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOW || r_q.st == ST_HIGH) |-> !cs_n);

    // R5
    clk_fall_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.addr) && $stable(r_q.pay)));
endmodule

// File: tb/nbw_writer_test.sv
`timescale 1ns/1ps
module nbw_writer_test;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  words = 2'd0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] payload = 16'h0000;
    logic        sdi;
    logic        cs_n, sclk, sdo, busy, done, err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // fault injection and monitor state
    logic        inj_en = 1'b0;
    int          inj_k = 0;
    logic        mon_clr = 1'b0;
    int          rises, low_run, high_run, setup_run, hi_run, time_bad, cs_glitch;
    logic [26:0] rx;
    logic        prev_sclk, seen_fall, went_low;

    always #2.5 clk = ~clk;

    assign sdi = sdo ^ (inj_en && (rises == inj_k));

    nbw_writer #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .words(words),
        .reg_addr(reg_addr), .payload(payload), .sdi(sdi),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .busy(busy),
        .done(done), .err(err));

    always @(negedge clk) begin
        if (mon_clr) begin
            rises = 0; low_run = 0; high_run = 0; setup_run = 0; hi_run = 0;
            time_bad = 0; cs_glitch = 0; rx = '0; seen_fall = 1'b0;
            went_low = 1'b0; prev_sclk = sclk;
        end else begin
            if (!cs_n) went_low = 1'b1;
            if (cs_n && !went_low) hi_run++;
            if (cs_n && went_low && busy) cs_glitch++;
            if (!cs_n) begin
                if (sclk && !prev_sclk) begin
                    rx = {rx[25:0], sdo};
                    rises++;
                    if (low_run != HALF) time_bad++;
                    low_run = 0;
                end
                if (!sclk && prev_sclk && seen_fall) begin
                    if (high_run != HALF) time_bad++;
                    high_run = 0;
                end
                if (!sclk) begin
                    seen_fall = 1'b1;
                    low_run++;
                end else if (seen_fall) begin
                    high_run++;
                end else begin
                    setup_run++;
                end
            end
            prev_sclk = sclk;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_nbits(input logic [1:0] c);
        return (c <= 2'd1) ? 9 : 9 * int'(c);
    endfunction

    function automatic logic [26:0] exp_stream(input logic [1:0] c, input logic [7:0] a,
                                               input logic [15:0] p);
        logic [26:0] v;
        if (c <= 2'd1)      v = {18'd0, 1'b0, a};
        else if (c == 2'd2) v = {9'd0, 1'b0, a, 1'b1, p[7:0]};
        else                v = {1'b0, a, 1'b1, p[15:8], 1'b1, p[7:0]};
        return v;
    endfunction

    // send a frame; kflt < 0 means no injected fault
    task automatic run_frame(input logic [1:0] c, input logic [7:0] a, input logic [15:0] p,
                             input int kflt, input int exp_gap, input bit poke);
        int nb, lim, kk;
        logic [26:0] full, want, mask;
        nb   = exp_nbits(c);
        full = exp_stream(c, a, p);
        @(posedge clk); #1;
        words = c; reg_addr = a; payload = p;
        inj_en = (kflt >= 0); inj_k = kflt;
        mon_clr = 1'b1; start = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0; start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        lim = 0;
        while (!done && lim < 2000) begin
            if (poke && lim == 20) begin
                @(posedge clk); #1;
                start = 1'b1; reg_addr = ~a; payload = ~p; words = 2'd1;
                @(posedge clk); #1;
                start = 1'b0;
            end
            @(negedge clk);
            lim++;
        end
        chk(done == 1'b1, "R7 done seen", done, 1);
        chk(hi_run == exp_gap, "R9 cs high before frame", hi_run, exp_gap);
        chk(setup_run == HALF, "R4 cs lead before first clock fall", setup_run, HALF);
        chk(time_bad == 0, "R5 half-period lengths", time_bad, 0);
        if (kflt < 0) begin
            chk(err == 1'b0, "R7 err clear on clean frame", err, 0);
            chk(cs_n == 1'b1 && sclk == 1'b1, "R4 cs/clk high at done", {cs_n, sclk}, 3);
            chk(rises == nb, "R3 bit count", rises, nb);
            mask = (27'd1 << nb) - 27'd1;
            chk((rx & mask) == full, "R2 R3 bit stream", rx & mask, full);
            chk(cs_glitch == 0, "R4 cs held low", cs_glitch, 0);
            chk(high_run == HALF, "R5 last high half", high_run, HALF);
        end else begin
            kk = kflt;
            chk(err == 1'b1, "R6 err on echo mismatch", err, 1);
            chk(cs_n == 1'b0, "R6 cs left low", cs_n, 0);
            chk(rises == kk, "R6 stop at faulty bit", rises, kk);
            mask = (27'd1 << kk) - 27'd1;
            want = (kk == 0) ? 27'd0 : (full >> (nb - kk));
            chk((rx & mask) == want, "R6 bits before fault", rx & mask, want);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle", {done, busy}, 0);
        if (poke) begin
            repeat (4 * HALF) @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R8 no extra frame", {done, busy}, 0);
        end
        inj_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pa [4];
        logic [15:0] pp [4];
        pa[0] = 8'h00; pa[1] = 8'hFF; pa[2] = 8'hA5; pa[3] = 8'h3C;
        pp[0] = 16'h0000; pp[1] = 16'hFFFF; pp[2] = 16'h5AC3; pp[3] = 16'h81E7;
        repeat (3) @(posedge clk);
        #1;
        chk(cs_n == 1'b1 && sclk == 1'b1 && sdo == 1'b0, "R1 reset pins",
            {cs_n, sclk, sdo}, 6);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // sweep of word counts and data patterns
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                run_frame(2'(c), pa[i], pp[(i + c) % 4], -1, 0, 1'b0);
        // start pulse while busy (R8)
        run_frame(2'd3, 8'h5E, 16'h1234, -1, 0, 1'b1);
        // fault at every bit position, each followed by a clean frame (R6, R9)
        for (int k = 0; k < 27; k++) begin
            run_frame(2'd3, 8'hC6, 16'h9D2B, k, 0, 1'b0);
            run_frame(2'd2, 8'h17, 16'h00E4, -1, HALF, 1'b0);
        end
        // fault in a single-word frame, then a fault right after a gap
        run_frame(2'd1, 8'h81, 16'h0000, 8, 0, 1'b0);
        run_frame(2'd1, 8'h81, 16'h0000, 0, HALF, 1'b0);
        run_frame(2'd1, 8'h42, 16'h0000, -1, HALF, 1'b0);
        run_frame(2'd1, 8'h42, 16'h0000, -1, 0, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule